// File: doc/BRIEF.md
# SDRAM Command Encoder with Per-Bank State Tracking

This block sits between a memory controller's scheduler and the command pins of a four-bank synchronous DRAM. The scheduler offers one abstract request at a time over a valid/ready handshake. The request is a mode register load, a row activate, a precharge of one bank, or a precharge of every bank. The block turns each accepted request into the chip-select, RAS, CAS and WE strobes, the bank-select pair and the 11-bit address. When nothing is issued, it drives a no-operation.

The block keeps an idle or active flag and the open row for each bank. It refuses requests that the device would not accept. There are two kinds of refusal. A request that can never become legal in the present state is dropped and raises a one-cycle error pulse. A request that only has to wait is held with ready low until it becomes legal: an activate inside the precharge-to-activate window of its bank waits this way, and so does any request made in the quiet period after a mode register load.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While reset is held and on the first cycle after it, the bus shows a no-operation, `bank_active` is 0, `open_rows` is 0 and `err_pulse` is low.
- R2: A mode load is requested with `req_kind` = 0. One cycle after it is accepted, all four strobes are low, `cmd_ba` equals `req_bank` and `cmd_addr` equals `req_row`.
- R3: A mode load is accepted only when every bank is idle. If any bank is active, the request is taken (ready high) and dropped, and `err_pulse` is high for the next cycle while the bus shows a no-operation.
- R4: For the two cycles after a mode load appears on the bus, the bus shows a no-operation. During those cycles `req_ready` is low for every kind of request.
- R5: Until the first mode load has been issued, activate and precharge requests are taken and dropped, with a one-cycle `err_pulse`.
- R6: An activate is requested with `req_kind` = 1. One cycle after it is accepted, CS and RAS are low, CAS and WE are high, `cmd_ba` is the bank and `cmd_addr` is the row. On the same edge, bit b of `bank_active` rises, and bits b*11 to b*11+10 of `open_rows` take the row.
- R7: An activate to a bank that is already active is taken and dropped with a one-cycle `err_pulse`, and the bank's row is left unchanged.
- R8: A precharge of a single bank is requested with `req_kind` = 2. It shows CS, RAS and WE low, CAS high, address bit 10 low with all other address bits zero, and `cmd_ba` set to the bank. That bank goes idle.
- R9: A precharge of all banks is requested with `req_kind` = 3. It shows the precharge strobes, address bit 10 high with all other address bits zero, and `cmd_ba` = 0 whatever `req_bank` holds. All banks go idle.
- R10: An activate to a bank is held with `req_ready` low until at least TRP cycles (default 3) separate that bank's last precharge on the bus from the activate on the bus. Other banks are not held.
- R11: In every cycle without an issued command, the bus shows a no-operation: CS low, and RAS, CAS and WE high.
- R12: A request takes effect only on a clock edge where `req_valid` and `req_ready` are both high. The command or error appears exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | 0 mode load, 1 activate, 2 precharge one, 3 precharge all |
| req_bank | input | 2 | Target bank, or upper value bits for a mode load |
| req_row | input | 11 | Row address, or lower value bits for a mode load |
| cmd_cs_n | output | 1 | Chip-select strobe |
| cmd_ras_n | output | 1 | Row strobe |
| cmd_cas_n | output | 1 | Column strobe |
| cmd_we_n | output | 1 | Write-enable strobe |
| cmd_ba | output | 2 | Bank-select pair |
| cmd_addr | output | 11 | Address bus |
| err_pulse | output | 1 | One-cycle flag for a dropped request |
| bank_active | output | 4 | Bit b set while bank b is active |
| open_rows | output | 44 | Open row of bank b in bits b*11 to b*11+10 |

## Verification
`req_ready` is combinational and is compared in the same cycle the request is offered. The strobes, bank-select, address and error pulse are registered and are due one edge after acceptance. `bank_active` and `open_rows` change on that same edge. The bench keeps a behavioural model that advances on the same edge as the design and compares every output half a period later. For the two timing windows, the bench counts the cycles in which a request was held: two after a mode load, and TRP-1 after a precharge with the default TRP.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [1:0] {
    REQ_MODE   = 2'd0,
    REQ_ACT    = 2'd1,
    REQ_PRE    = 2'd2,
    REQ_PREALL = 2'd3
  } req_kind_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } strobe_t;

  localparam strobe_t STRB_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam strobe_t STRB_MODE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
  localparam strobe_t STRB_ACT  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
  localparam strobe_t STRB_PRE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};

  // Strobe pattern for a request kind
  function automatic strobe_t strobes_for(req_kind_e k);
    case (k)
      REQ_MODE: return STRB_MODE;
      REQ_ACT:  return STRB_ACT;
      default:  return STRB_PRE;
    endcase
  endfunction

endpackage

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int ROW_W = 11,
  parameter int TRP   = 3,
  localparam int TRP_W = $clog2(TRP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_go,
  input  logic             pre_go,
  input  logic [ROW_W-1:0] row_in,
  output logic             active_q,
  output logic [ROW_W-1:0] row_q,
  output logic             trp_busy
);

  logic [TRP_W-1:0] trp_cnt;

  function automatic logic [TRP_W-1:0] count_down(logic [TRP_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      row_q    <= '0;
      trp_cnt  <= '0;
    end else begin
      if (pre_go) begin
        active_q <= 1'b0;
        trp_cnt  <= TRP_W'(TRP - 1);
      end else begin
        trp_cnt <= count_down(trp_cnt);
        if (act_go) begin
          active_q <= 1'b1;
          row_q    <= row_in;
        end
      end
    end
  end

  assign trp_busy = (trp_cnt != '0);

  p_act_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |-> !active_q);
  p_act_after_trp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |-> !trp_busy);
  p_pre_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pre_go |=> !active_q);
  p_act_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_go && !pre_go) |=> (active_q && row_q == $past(row_in)));

endmodule

// File: rtl/sdram_mode_guard.sv
module sdram_mode_guard #(
  parameter int MRS_GAP = 2,
  localparam int GAP_W = $clog2(MRS_GAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_go,
  output logic init_q,
  output logic locked
);

  logic [GAP_W-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q  <= 1'b0;
      gap_cnt <= '0;
    end else if (mode_go) begin
      init_q  <= 1'b1;
      gap_cnt <= GAP_W'(MRS_GAP);
    end else if (gap_cnt != '0) begin
      gap_cnt <= gap_cnt - 1'b1;
    end
  end

  assign locked = (gap_cnt != '0);

  p_gap_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_go |=> (init_q && (locked || MRS_GAP == 0)));
  p_no_mode_while_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !mode_go);

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
  import sdram_cmd_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  strobe_t          fire_strb,
  input  logic [BA_W-1:0]  fire_ba,
  input  logic [ROW_W-1:0] fire_addr,
  input  logic             err_in,
  output strobe_t          strb_q,
  output logic [BA_W-1:0]  ba_q,
  output logic [ROW_W-1:0] addr_q,
  output logic             err_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strb_q <= STRB_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      err_q  <= 1'b0;
    end else begin
      strb_q <= fire ? fire_strb : STRB_NOP;
      ba_q   <= fire ? fire_ba   : '0;
      addr_q <= fire ? fire_addr : '0;
      err_q  <= err_in;
    end
  end

  p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (strb_q == STRB_NOP));
  p_one_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (strb_q == $past(fire_strb)));

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_cmd_pkg::*;
#(
  parameter int NBANK   = 4,
  parameter int ROW_W   = 11,
  parameter int TRP     = 3,
  parameter int MRS_GAP = 2,
  parameter int AP_BIT  = 10,
  localparam int BA_W   = $clog2(NBANK)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [1:0]             req_kind,
  input  logic [BA_W-1:0]        req_bank,
  input  logic [ROW_W-1:0]       req_row,
  output logic                   cmd_cs_n,
  output logic                   cmd_ras_n,
  output logic                   cmd_cas_n,
  output logic                   cmd_we_n,
  output logic [BA_W-1:0]        cmd_ba,
  output logic [ROW_W-1:0]       cmd_addr,
  output logic                   err_pulse,
  output logic [NBANK-1:0]       bank_active,
  output logic [NBANK*ROW_W-1:0] open_rows
);

  req_kind_e        kind;
  logic [NBANK-1:0] trp_busy;
  logic [NBANK-1:0] act_go;
  logic [NBANK-1:0] pre_go;
  logic             init_q;
  logic             locked;
  logic             all_idle;
  logic             bad;
  logic             hold;
  logic             fire_any;
  logic             fire_ok;
  logic             err_now;
  logic             mode_go;
  logic [BA_W-1:0]  bus_ba;
  logic [ROW_W-1:0] bus_addr;
  strobe_t          strb_q;

  // Address for a precharge: only the all-banks bit may be set
  function automatic logic [ROW_W-1:0] pre_addr(logic all_banks);
    logic [ROW_W-1:0] a;
    a = '0;
    a[AP_BIT] = all_banks;
    return a;
  endfunction

  assign kind     = req_kind_e'(req_kind);
  assign all_idle = (bank_active == '0);

  always_comb begin
    bad  = 1'b0;
    hold = 1'b0;
    case (kind)
      REQ_MODE: bad = !all_idle;
      REQ_ACT: begin
        bad  = !init_q || bank_active[req_bank];
        hold = !bad && trp_busy[req_bank];
      end
      default: bad = !init_q;
    endcase
  end

  assign req_ready = !locked && !hold;
  assign fire_any  = req_valid && req_ready;
  assign fire_ok   = fire_any && !bad;
  assign err_now   = fire_any && bad;
  assign mode_go   = fire_ok && (kind == REQ_MODE);

  always_comb begin
    case (kind)
      REQ_PRE:    begin bus_ba = req_bank; bus_addr = pre_addr(1'b0); end
      REQ_PREALL: begin bus_ba = '0;       bus_addr = pre_addr(1'b1); end
      default:    begin bus_ba = req_bank; bus_addr = req_row;        end
    endcase
  end

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    assign act_go[i] = fire_ok && (kind == REQ_ACT) && (req_bank == BA_W'(i));
    assign pre_go[i] = fire_ok && ((kind == REQ_PREALL) ||
                                   ((kind == REQ_PRE) && (req_bank == BA_W'(i))));
    sdram_bank_slot #(.ROW_W(ROW_W), .TRP(TRP)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_go   (act_go[i]),
      .pre_go   (pre_go[i]),
      .row_in   (req_row),
      .active_q (bank_active[i]),
      .row_q    (open_rows[i*ROW_W +: ROW_W]),
      .trp_busy (trp_busy[i])
    );
  end

  sdram_mode_guard #(.MRS_GAP(MRS_GAP)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_go (mode_go),
    .init_q  (init_q),
    .locked  (locked)
  );

  sdram_cmd_drive #(.BA_W(BA_W), .ROW_W(ROW_W)) u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire_ok),
    .fire_strb (strobes_for(kind)),
    .fire_ba   (bus_ba),
    .fire_addr (bus_addr),
    .err_in    (err_now),
    .strb_q    (strb_q),
    .ba_q      (cmd_ba),
    .addr_q    (cmd_addr),
    .err_q     (err_pulse)
  );

  assign cmd_cs_n  = strb_q.cs_n;
  assign cmd_ras_n = strb_q.ras_n;
  assign cmd_cas_n = strb_q.cas_n;
  assign cmd_we_n  = strb_q.we_n;

  logic bus_mode, bus_nop, bus_act_pre;
  assign bus_mode    = (strb_q == STRB_MODE);
  assign bus_nop     = (strb_q == STRB_NOP);
  assign bus_act_pre = (strb_q == STRB_ACT) || (strb_q == STRB_PRE);

  p_mode_all_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mode |-> ($past(bank_active) == '0));
  p_mode_silence_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mode |=> bus_nop);
  p_mode_silence_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mode |=> ##1 bus_nop);
  p_needs_init_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_act_pre |-> $past(init_q));
  p_err_single_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_go));

endmodule

// File: tb/test_sdram_cmd_tracker.sv
module test_sdram_cmd_tracker;

  localparam int CLK_PERIOD = 10;
  localparam int TRP        = 3;
  localparam int GAP        = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic [1:0]  req_bank = 2'd0;
  logic [10:0] req_row = 11'd0;
  logic        cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic [1:0]  cmd_ba;
  logic [10:0] cmd_addr;
  logic        err_pulse;
  logic [3:0]  bank_active;
  logic [43:0] open_rows;

  int n_tests = 0;
  int n_failed = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdram_cmd_tracker i_sdram_cmd_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_bank(req_bank), .req_row(req_row),
    .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
    .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr),
    .err_pulse(err_pulse), .bank_active(bank_active), .open_rows(open_rows)
  );

  // Behavioural reference state
  int m_init, m_lock;
  int m_act[4];
  int m_row[4];
  int m_wait[4];
  logic [3:0]  e_strb;
  logic [1:0]  e_ba;
  logic [10:0] e_addr;
  logic        e_err;

  function automatic bit model_ready(int k, int b);
    if (m_lock > 0) return 0;
    if (k == 1 && m_init != 0 && m_act[b] == 0 && m_wait[b] > 0) return 0;
    return 1;
  endfunction

  task automatic model_reset();
    m_init = 0; m_lock = 0;
    for (int i = 0; i < 4; i++) begin m_act[i] = 0; m_row[i] = 0; m_wait[i] = 0; end
    e_strb = 4'b0111; e_ba = 0; e_addr = 0; e_err = 0;
  endtask

  task automatic model_edge(bit v, int k, int b, int r);
    bit go;
    bit drop;
    go = v && model_ready(k, b);
    if (m_lock > 0) m_lock--;
    for (int i = 0; i < 4; i++) if (m_wait[i] > 0) m_wait[i]--;
    e_strb = 4'b0111; e_ba = 0; e_addr = 0; e_err = 0;
    if (go) begin
      if (k == 0) drop = (m_act[0] + m_act[1] + m_act[2] + m_act[3]) != 0;
      else if (k == 1) drop = (m_init == 0) || (m_act[b] != 0);
      else drop = (m_init == 0);
      if (drop) e_err = 1;
      else begin
        case (k)
          0: begin e_strb = 4'b0000; e_ba = b[1:0]; e_addr = r[10:0]; m_init = 1; m_lock = GAP; end
          1: begin e_strb = 4'b0011; e_ba = b[1:0]; e_addr = r[10:0]; m_act[b] = 1; m_row[b] = r; end
          2: begin e_strb = 4'b0010; e_ba = b[1:0]; e_addr = 0; m_act[b] = 0; m_wait[b] = TRP - 1; end
          default: begin
            e_strb = 4'b0010; e_ba = 0; e_addr = 11'h400;
            for (int i = 0; i < 4; i++) begin m_act[i] = 0; m_wait[i] = TRP - 1; end
          end
        endcase
      end
    end
  endtask

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_failed++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs(string tag);
    logic [3:0]  e_active;
    logic [43:0] e_rows;
    for (int i = 0; i < 4; i++) begin
      e_active[i] = (m_act[i] != 0);
      e_rows[i*11 +: 11] = m_row[i][10:0];
    end
    check(tag, "strobes", {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}, e_strb);
    check(tag, "bank select", cmd_ba, e_ba);
    check(tag, "address", cmd_addr, e_addr);
    check(tag, "error pulse", err_pulse, e_err);
    check(tag, "bank_active", bank_active, e_active);
    check(tag, "open_rows", open_rows, e_rows);
  endtask

  // One cycle: entered and left just after a falling edge
  task automatic step(bit v, int k, int b, int r, string tag, output bit acc);
    bit exp_rdy;
    req_valid = v; req_kind = k[1:0]; req_bank = b[1:0]; req_row = r[10:0];
    #1;
    exp_rdy = model_ready(k, b);
    check(tag, "req_ready", req_ready, exp_rdy);
    acc = v && exp_rdy;
    @(posedge clk);
    model_edge(v, k, b, r);
    @(negedge clk);
    check_outputs(tag);
  endtask

  task automatic go(bit v, int k, int b, int r, string tag);
    bit acc;
    step(v, k, b, r, tag, acc);
  endtask

  // Offer a request until taken; return cycles it was held
  task automatic until_taken(int k, int b, int r, string tag, output int holds);
    bit acc;
    holds = 0;
    step(1, k, b, r, tag, acc);
    while (!acc && holds < 50) begin
      holds++;
      step(1, k, b, r, tag, acc);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_failed++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_failed);
    $finish;
  end

  initial begin
    int holds;
    int seed;
    model_reset();
    repeat (3) @(negedge clk);
    check_outputs("R1");
    rst_n = 1'b1;
    go(0, 0, 0, 0, "R1");

    // Before any mode load
    go(1, 1, 2, 11'h123, "R5");
    go(1, 2, 0, 0, "R5");
    go(1, 3, 1, 0, "R5");

    // Mode load, then an activate held by the quiet window
    go(1, 0, 2, 11'h155, "R2");
    until_taken(1, 0, 11'h2AA, "R4", holds);
    check("R4", "held cycles after mode load", holds, GAP);

    go(1, 1, 1, 11'h7A3, "R6");
    go(1, 1, 1, 11'h011, "R7");
    go(1, 1, 3, 11'h005, "R6");
    go(1, 0, 0, 11'h3FF, "R3");

    // Single precharge and the wait window
    go(1, 2, 1, 11'h7FF, "R8");
    go(1, 1, 2, 11'h0F0, "R10");
    until_taken(1, 1, 11'h333, "R10", holds);
    check("R10", "held cycles after precharge", holds, TRP - 2);
    go(1, 2, 3, 0, "R8");
    until_taken(1, 1, 11'h444, "R7", holds);
    check("R7", "repeat activate dropped, not held", holds, 0);

    // Precharge all with a nonzero bank field, then a legal mode load
    go(1, 3, 3, 11'h0AB, "R9");
    until_taken(1, 0, 11'h222, "R10", holds);
    check("R10", "activate after precharge-all held", holds, TRP - 1);
    go(1, 2, 0, 0, "R8");
    go(1, 3, 2, 0, "R9");
    go(1, 0, 1, 11'h031, "R3");
    repeat (4) go(0, 1, 0, 11'h111, "R11");

    // Mixed traffic
    seed = 32'h1ACE;
    for (int n = 0; n < 400; n++) begin
      seed = seed * 1103515245 + 12345;
      go((seed >>> 4) % 4 != 0, (seed >>> 8) & 3, (seed >>> 12) & 3,
         (seed >>> 16) & 11'h7FF, "R12");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_failed);
    $finish;
  end

endmodule